// File: doc/BRIEF.md
# Standby Wake-Up Sequencer

This block decides when the chip's core clock may stop and when it may start again. Software arms standby by setting an enable bit through a small write port and then raises a sleep request. The block gates the clock and waits for a wake source: the non-maskable interrupt, any discrete IRQ line, an encoded interrupt level above the current mask, or a peripheral request. The interval-timer peripheral is not a wake source.

A wake does not restart the clock at once. A preloadable 8-bit counter, advanced by a slow tick, times oscillator and PLL settling. The clock returns only when that counter overflows. At that point the block pulses an interrupt-entry strobe and publishes a code naming the wake source.

The counter then keeps running as a guard. If software does not clear the enable bit before the count reaches 0x80, the block drops back into standby. This protects against a core that came up on an unstable supply and never reached its handler. Clearing the bit stops the counter where it stands.

Top module: `stby_wake_ctrl`

## Requirements
- R1: While power-on reset (`rst_n` low) is applied, and directly after it, `clk_en` is 1, `stat` is 00, `intr_start` is 0, and both `evt_code` and `guard_cnt` are 0.
- R2: Writes with `wr_sel`=0 set the standby-enable bit from `wr_data[0]`. A `sleep_req` pulse while that bit is 1 gates the clock on the next edge: `clk_en` becomes 0 and `stat` becomes 11. When the bit is 0, `sleep_req` has no effect.
- R3: While in standby, any of these wakes the block: `nmi`, any `irq` bit, or any `periph_req` bit other than index 0. Index 0 is the interval timer, and it never wakes the block.
- R4: While in standby, `int_level` wakes the block only when it is strictly greater than `mask_level`. An equal level does not wake it.
- R5: Writes with `wr_sel`=1 preload `guard_cnt` from `wr_data`. After a wake, `clk_en` stays 0 while the counter advances by one on each cycle where `tick` is 1. The clock returns on the edge where the count at 0xFF ticks over to 0, so the time spent settling is 256 minus the preload, counted in ticks.
- R6: On exit, `clk_en` becomes 1, `stat` becomes 00, and `intr_start` is high for exactly one cycle. On that same edge `evt_code` takes the wake source's code and does not change at any other time. The codes are:
  - NMI: 0x1C0
  - IRQ line n: 0x200+0x20·n
  - peripheral index p: 0x400+0x20·p
  - encoded level L: 0x600+0x20·L

  When several sources wake in the same cycle, priority is NMI first, then IRQ lines from lowest to highest, then level, then peripherals from lowest index.
- R7: After exit, `guard_cnt` restarts at 0 and keeps counting on `tick`. When it reaches 0x80 while the enable bit is still 1, the block re-enters standby (`clk_en` 0, `stat` 11).
- R8: A write that clears the enable bit after exit returns the block to normal running. `guard_cnt` then holds its value.
- R9: Writes are ignored while the clock is gated. This applies both to standby and to settling.
- R10: While running, the wake inputs have no effect: `clk_en`, `intr_start` and `evt_code` stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock for the controller |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sleep_req | input | 1 | Sleep request pulse from the core |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: enable bit, 1: counter preload |
| wr_data | input | CNT_W (8) | Write data |
| tick | input | 1 | Slow count enable for the settling/guard counter |
| nmi | input | 1 | Non-maskable interrupt |
| irq | input | NUM_IRQ (5) | Discrete interrupt lines |
| int_level | input | LVL_W (4) | Encoded interrupt level |
| mask_level | input | LVL_W (4) | Current interrupt mask level |
| periph_req | input | NUM_PER (4) | Peripheral requests, index 0 is the interval timer |
| clk_en | output | 1 | Core clock enable |
| stat | output | 2 | 11 while the clock is gated, 00 while running |
| intr_start | output | 1 | One-cycle strobe at standby exit |
| evt_code | output | 12 | Code of the source that caused the last exit |
| guard_cnt | output | CNT_W (8) | Settling/guard counter value |

## Verification
The assertions assume a few things about the inputs:
- `tick` and `wr_en` are the only reasons `guard_cnt` moves.
- The clock only falls through a sleep request or a guard expiry.
- No reset arrives in the middle of a wake sequence.

The bench respects all of these. It changes the wake inputs only at falling edges. It applies reset once, at the start. It preloads the counter only while running. It holds `tick` high throughout, so every settle and guard interval is an exact cycle count that can be predicted from the preload.

// File: rtl/stby_wake_pkg.sv
package stby_wake_pkg;

   typedef enum logic [1:0] {
      ST_RUN    = 2'd0,
      ST_STBY   = 2'd1,
      ST_SETTLE = 2'd2,
      ST_GUARD  = 2'd3
   } stby_state_t;

   localparam int EVT_W = 12;
   localparam logic [EVT_W-1:0] EVT_NMI      = 12'h1C0;
   localparam logic [EVT_W-1:0] EVT_IRQ_BASE = 12'h200;
   localparam logic [EVT_W-1:0] EVT_PER_BASE = 12'h400;
   localparam logic [EVT_W-1:0] EVT_LVL_BASE = 12'h600;
   localparam int               EVT_STEP     = 32;

   localparam logic [1:0] STAT_RUN   = 2'b00;
   localparam logic [1:0] STAT_GATED = 2'b11;

endpackage

// File: rtl/stby_wake_src.sv
module stby_wake_src
   import stby_wake_pkg::*;
#(
   parameter int NUM_IRQ   = 5,
   parameter int NUM_PER   = 4,
   parameter int LVL_W     = 4,
   parameter int TIMER_IDX = 0
) (
   input  logic               nmi,
   input  logic [NUM_IRQ-1:0] irq,
   input  logic [LVL_W-1:0]   int_level,
   input  logic [LVL_W-1:0]   mask_level,
   input  logic [NUM_PER-1:0] periph_req,
   output logic               wake,
   output logic [EVT_W-1:0]   code
);

   logic [NUM_PER-1:0] per_ok;
   logic               lvl_ok;

   // The interval-timer request is stripped from the peripheral set.
   for (genvar p = 0; p < NUM_PER; p++) begin : g_per_mask
      if (p == TIMER_IDX) begin : g_timer
         assign per_ok[p] = 1'b0;
      end else begin : g_other
         assign per_ok[p] = periph_req[p];
      end
   end

   assign lvl_ok = (int_level > mask_level);
   assign wake   = nmi | (|irq) | lvl_ok | (|per_ok);

   // Fixed priority: NMI, IRQ low->high, level, peripheral low->high.
   always_comb begin
      logic found;
      found = 1'b0;
      code  = '0;
      if (nmi) begin
         code  = EVT_NMI;
         found = 1'b1;
      end
      for (int i = 0; i < NUM_IRQ; i++) begin
         if (!found && irq[i]) begin
            code  = EVT_IRQ_BASE + EVT_W'(i * EVT_STEP);
            found = 1'b1;
         end
      end
      if (!found && lvl_ok) begin
         code  = EVT_LVL_BASE + EVT_W'(int'(int_level) * EVT_STEP);
         found = 1'b1;
      end
      for (int p = 0; p < NUM_PER; p++) begin
         if (!found && per_ok[p]) begin
            code  = EVT_PER_BASE + EVT_W'(p * EVT_STEP);
            found = 1'b1;
         end
      end
   end

endmodule

// File: rtl/stby_settle_cnt.sv
module stby_settle_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt,
   output logic             at_max,
   output logic [CNT_W-1:0] cnt_next_inc
);

   assign at_max       = (cnt == {CNT_W{1'b1}});
   assign cnt_next_inc = cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (inc) begin
         cnt <= cnt_next_inc;
      end
   end

endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
   import stby_wake_pkg::*;
#(
   parameter int               NUM_IRQ     = 5,
   parameter int               NUM_PER     = 4,
   parameter int               LVL_W       = 4,
   parameter int               TIMER_IDX   = 0,
   parameter int               CNT_W       = 8,
   parameter logic [CNT_W-1:0] GUARD_LIMIT = 8'h80
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sleep_req,
   input  logic               wr_en,
   input  logic               wr_sel,
   input  logic [CNT_W-1:0]   wr_data,
   input  logic               tick,
   input  logic               nmi,
   input  logic [NUM_IRQ-1:0] irq,
   input  logic [LVL_W-1:0]   int_level,
   input  logic [LVL_W-1:0]   mask_level,
   input  logic [NUM_PER-1:0] periph_req,
   output logic               clk_en,
   output logic [1:0]         stat,
   output logic               intr_start,
   output logic [EVT_W-1:0]   evt_code,
   output logic [CNT_W-1:0]   guard_cnt
);

   // Elaboration-time parameter checks
   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("CNT_W must be at least 2");
   end
   if (GUARD_LIMIT == '0) begin : g_bad_limit
      $error("GUARD_LIMIT must be non-zero");
   end
   if (TIMER_IDX < 0 || TIMER_IDX >= NUM_PER) begin : g_bad_timer
      $error("TIMER_IDX out of peripheral range");
   end
   if (NUM_IRQ < 1 || NUM_PER < 1 || LVL_W < 1) begin : g_bad_count
      $error("source counts and level width must be positive");
   end

   stby_state_t      state_q, state_d;
   logic             stby_en_q, stby_en_nx;
   logic             clk_on;
   logic             wr_ok, ctrl_wr, cnt_wr;
   logic             wake;
   logic [EVT_W-1:0] wake_code, pend_code_q;
   logic             cnt_inc, cnt_at_max;
   logic [CNT_W-1:0] cnt_plus1;
   logic             settle_done, guard_hit;

   stby_wake_src #(
      .NUM_IRQ   (NUM_IRQ),
      .NUM_PER   (NUM_PER),
      .LVL_W     (LVL_W),
      .TIMER_IDX (TIMER_IDX)
   ) u_src (
      .nmi        (nmi),
      .irq        (irq),
      .int_level  (int_level),
      .mask_level (mask_level),
      .periph_req (periph_req),
      .wake       (wake),
      .code       (wake_code)
   );

   stby_settle_cnt #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (cnt_wr),
      .load_val     (wr_data),
      .inc          (cnt_inc),
      .cnt          (guard_cnt),
      .at_max       (cnt_at_max),
      .cnt_next_inc (cnt_plus1)
   );

   // Software can only act while the core clock runs.
   assign clk_on     = (state_q == ST_RUN) || (state_q == ST_GUARD);
   assign wr_ok      = wr_en && clk_on;
   assign ctrl_wr    = wr_ok && !wr_sel;
   assign cnt_wr     = wr_ok && wr_sel;
   assign stby_en_nx = ctrl_wr ? wr_data[0] : stby_en_q;

   assign cnt_inc = tick && ((state_q == ST_SETTLE) ||
                             ((state_q == ST_GUARD) && stby_en_nx));

   assign settle_done = (state_q == ST_SETTLE) && tick && cnt_at_max;
   assign guard_hit   = cnt_inc && (state_q == ST_GUARD) && !cnt_wr &&
                        (cnt_plus1 == GUARD_LIMIT);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN:    if (sleep_req && stby_en_q) state_d = ST_STBY;
         ST_STBY:   if (wake) state_d = ST_SETTLE;
         ST_SETTLE: if (settle_done) state_d = ST_GUARD;
         ST_GUARD: begin
            if (!stby_en_nx)    state_d = ST_RUN;
            else if (guard_hit) state_d = ST_STBY;
         end
         default:   state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_RUN;
         stby_en_q   <= 1'b0;
         pend_code_q <= '0;
         evt_code    <= '0;
         intr_start  <= 1'b0;
      end else begin
         state_q    <= state_d;
         stby_en_q  <= stby_en_nx;
         intr_start <= settle_done;
         if (state_q == ST_STBY && wake) begin
            pend_code_q <= wake_code;
         end
         if (settle_done) begin
            evt_code <= pend_code_q;
         end
      end
   end

   assign clk_en = clk_on;
   assign stat   = clk_on ? STAT_RUN : STAT_GATED;

endmodule

// File: rtl/stby_wake_checker.sv
module stby_wake_checker #(
   parameter int               CNT_W       = 8,
   parameter logic [CNT_W-1:0] GUARD_LIMIT = 8'h80
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sleep_req,
   input logic             wr_en,
   input logic             tick,
   input logic             clk_en,
   input logic [1:0]       stat,
   input logic             intr_start,
   input logic [11:0]      evt_code,
   input logic [CNT_W-1:0] guard_cnt
);

   p_gated_stat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |-> stat == 2'b11)
      else $error("gated clock without gated status");

   p_run_stat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en |-> stat == 2'b00)
      else $error("running clock without run status");

   p_cnt_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (guard_cnt != $past(guard_cnt)) |-> ($past(tick) || $past(wr_en)))
      else $error("counter moved without tick or write");

   p_exit_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_en) |-> (intr_start && guard_cnt == '0))
      else $error("clock returned without overflow and strobe");

   p_strobe_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      intr_start |=> !intr_start)
      else $error("interrupt strobe longer than one cycle");

   p_evt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_code != $past(evt_code)) |-> intr_start)
      else $error("event code changed outside exit");

   p_gate_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_en) |-> ($past(sleep_req) || guard_cnt == GUARD_LIMIT))
      else $error("clock gated without sleep or guard expiry");

endmodule

bind stby_wake_ctrl stby_wake_checker #(
   .CNT_W       (CNT_W),
   .GUARD_LIMIT (GUARD_LIMIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sleep_req  (sleep_req),
   .wr_en      (wr_en),
   .tick       (tick),
   .clk_en     (clk_en),
   .stat       (stat),
   .intr_start (intr_start),
   .evt_code   (evt_code),
   .guard_cnt  (guard_cnt)
);

// File: tb/test_stby_wake_ctrl.sv
module test_stby_wake_ctrl;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        sleep_req, wr_en, wr_sel, tick, nmi;
   logic [7:0]  wr_data;
   logic [4:0]  irq;
   logic [3:0]  int_level, mask_level, periph_req;
   logic        clk_en, intr_start;
   logic [1:0]  stat;
   logic [11:0] evt_code;
   logic [7:0]  guard_cnt;

   int checks = 0;
   int errors = 0;
   logic [11:0] exp_q[$];

   always #5 clk = ~clk;

   stby_wake_ctrl i_stby_wake_ctrl (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .tick(tick), .nmi(nmi), .irq(irq),
      .int_level(int_level), .mask_level(mask_level), .periph_req(periph_req),
      .clk_en(clk_en), .stat(stat), .intr_start(intr_start),
      .evt_code(evt_code), .guard_cnt(guard_cnt)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Monitor: every exit strobe pops one expected code (R6).
   always @(negedge clk) begin
      if (rst_n === 1'b1 && intr_start === 1'b1) begin
         if (exp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R6 unexpected exit actual=%0h expected=none", evt_code);
         end else begin
            chk("R6 event code", {20'd0, evt_code}, {20'd0, exp_q.pop_front()});
         end
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic sel, logic [7:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      step(1);
      wr_en = 1'b0;
   endtask

   task automatic enter(logic [7:0] pre);
      wr(1'b0, 8'h01);
      wr(1'b1, pre);
      sleep_req = 1'b1;
      step(1);
      sleep_req = 1'b0;
      chk("R2 clock gated", clk_en, 0);
      chk("R2 gated status", stat, 2'b11);
   endtask

   // Driver: apply a wake pattern, push its expected code, time the settle.
   task automatic wake_exit(logic n, logic [4:0] iq, logic [3:0] lv,
                            logic [3:0] pr, logic [11:0] code, int cycles,
                            string req);
      int k;
      exp_q.push_back(code);
      nmi = n; irq = iq; int_level = lv; periph_req = pr;
      step(1);
      nmi = 1'b0; irq = '0; int_level = '0; periph_req = '0;
      chk({req, " settling keeps clock gated"}, clk_en, 0);
      k = 0;
      while (!clk_en && k < 400) begin
         step(1);
         k++;
      end
      chk("R5 settle length in ticks", k, cycles);
      chk("R6 run status on exit", stat, 2'b00);
      chk("R6 strobe on exit", intr_start, 1);
      chk("R7 guard restarts at zero", guard_cnt, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int k;
      rst_n = 1'b0; sleep_req = 0; wr_en = 0; wr_sel = 0; wr_data = '0;
      tick = 1'b1; nmi = 0; irq = '0; int_level = '0; mask_level = 4'd5;
      periph_req = '0;
      step(3);
      chk("R1 reset clk_en", clk_en, 1);
      chk("R1 reset stat", stat, 0);
      chk("R1 reset evt", evt_code, 0);
      chk("R1 reset cnt", guard_cnt, 0);
      chk("R1 reset strobe", intr_start, 0);
      rst_n = 1'b1;
      step(1);

      // R2: sleep without the enable bit does nothing
      sleep_req = 1'b1; step(1); sleep_req = 1'b0; step(1);
      chk("R2 sleep ignored when disabled", clk_en, 1);

      // R10: wake inputs while running have no effect
      nmi = 1'b1; irq = 5'h1F; periph_req = 4'hF; step(2);
      nmi = 1'b0; irq = '0; periph_req = '0;
      chk("R10 clock unchanged", clk_en, 1);
      chk("R10 no strobe", intr_start, 0);
      chk("R10 evt unchanged", evt_code, 0);

      enter(8'hFC);
      // R9: preload write while gated is ignored
      wr(1'b1, 8'h33);
      chk("R9 write ignored in standby", guard_cnt, 8'hFC);
      // R3: interval timer request alone does not wake
      periph_req = 4'b0001; step(3); periph_req = '0;
      chk("R3 timer request ignored", clk_en, 0);
      // R4: level equal to mask does not wake
      int_level = 4'd5; step(3); int_level = '0;
      chk("R4 equal level ignored", clk_en, 0);
      chk("R5 counter idle in standby", guard_cnt, 8'hFC);

      // R3/R6: NMI beats IRQ2
      wake_exit(1'b1, 5'b00100, 4'd0, 4'd0, 12'h1C0, 4, "R3 nmi");
      // R8: clear after 10 guard ticks halts the counter
      step(10);
      chk("R7 guard counting", guard_cnt, 10);
      wr(1'b0, 8'h00);
      chk("R8 counter halted on clear", guard_cnt, 10);
      step(5);
      chk("R8 counter stays halted", guard_cnt, 10);
      chk("R8 clock stays on", clk_en, 1);

      // R6: lowest IRQ wins
      enter(8'hFE);
      wake_exit(1'b0, 5'b01010, 4'd0, 4'd0, 12'h220, 2, "R3 irq");
      wr(1'b0, 8'h00);

      // R6: IRQ beats level
      enter(8'hFC);
      wake_exit(1'b0, 5'b00001, 4'd9, 4'd0, 12'h200, 4, "R3 irq0");
      wr(1'b0, 8'h00);

      // R4: level above mask
      enter(8'hFC);
      wake_exit(1'b0, 5'b0, 4'd6, 4'd0, 12'h6C0, 4, "R4 level");
      wr(1'b0, 8'h00);

      // R3: peripheral 2 wakes though timer also asserted; then R7 guard expiry
      enter(8'hFC);
      wake_exit(1'b0, 5'b0, 4'd0, 4'b0101, 12'h440, 4, "R3 periph");
      k = 0;
      while (clk_en && k < 400) begin
         step(1);
         k++;
      end
      chk("R7 guard expiry cycles", k, 128);
      chk("R7 counter at limit", guard_cnt, 8'h80);
      chk("R7 gated status again", stat, 2'b11);
      wake_exit(1'b1, 5'b0, 4'd0, 4'd0, 12'h1C0, 128, "R7 rewake");
      wr(1'b0, 8'h00);
      step(3);
      chk("R8 running after clear", clk_en, 1);
      chk("R6 all exits observed", exp_q.size(), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule